// File: doc/BRIEF.md
# Transmit Error Status and Interrupt Logic

This block gathers the fault conditions of a bus-mastering transmit controller into a bank of sticky status flags, and it drives one CPU interrupt line from them. There are six sources. An access to a fully reserved register, a FIFO fault level, an illegal controller state, excess retries within one bus transaction, a target abort and an initiator abort each set their own flag. Software reads the flags, enables or disables each one as an interrupt source, sets a retry limit, and clears flags by writing ones.

Software sees two 16-bit registers through a small read/write port. With the address at 0 the port selects the status register, which holds the flags. With the address at 1 it selects the control register, which holds the per-flag interrupt enables and the 8-bit retry limit. The block has its own retry counter. The counter restarts at every transaction-start marker, so a packet built from several transactions never accumulates retries across them. An illegal-state flag stays locked until the controller has been reset.

Top module: `tx_err_status`

## Requirements
- R1: After reset, both registers read 0x0000 and irq_o is low.
- R2: A pulse on rsvd_rd_i sets status bit 0 one clock later, whatever the state of enable bit 0. This flag drives irq_o only while control bit 0 is 1.
- R3: While fifo_err_i is high, status bit 1 is set on every clock. A write-one-to-clear has no effect until fifo_err_i falls.
- R4: A pulse on bad_state_i sets status bit 2. Writing 1 to clear this bit has no effect until a ctl_reset_i pulse has been seen. After that pulse the clear works.
- R5: The retry limit is control bits 15:8. A nonzero limit L means that the (L+1)-th retry_i pulse within one transaction sets status bit 3.
- R6: A txn_start_i pulse restarts the retry count at zero, so retries in separate transactions never add up.
- R7: A retry limit of 0x00 means unlimited retries: status bit 3 never sets, whatever the number of retries.
- R8: A tgt_abort_i pulse sets status bit 4, and an init_abort_i pulse sets status bit 5. No other flag changes.
- R9: Writing a 1 to a status bit clears that flag, and writing a 0 leaves it unchanged. If a set event and a clear arrive in the same cycle, the flag stays set.
- R10: irq_o is the OR over all bits of (flag AND enable), with control bits 5:0 as the enables. It follows that value one clock later.
- R11: Status bits 15:6 and control bits 7:6 always read zero. Writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rsvd_rd_i | input | 1 | Pulse: a slave read hit a fully reserved register |
| fifo_err_i | input | 1 | Level: the transmit FIFO reports an error |
| bad_state_i | input | 1 | Pulse: the transmit controller entered an illegal state |
| retry_i | input | 1 | Pulse: one bus retry occurred |
| txn_start_i | input | 1 | Pulse: a new bus transaction begins |
| tgt_abort_i | input | 1 | Pulse: the target aborted the transaction |
| init_abort_i | input | 1 | Pulse: the initiator aborted (no target responded) |
| ctl_reset_i | input | 1 | Pulse: the transmit controller is being reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 selects status, 1 selects control |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| irq_o | output | 1 | CPU interrupt request |

## Verification
The hardest situations to reach are the ones where the retry count sits at the limit while a transaction boundary falls between retries. The bench covers this in three steps. It programs a small limit and sends exactly the limit's worth of retries, then it sends one more. It also splits the same retries across several start markers, so that a counter that accumulates would be seen to trip. The unlimited case is driven with more retries than the 8-bit field can hold. The locked illegal-state flag is reached by a fixed sequence: a clear attempt before the controller reset and another one after it.

// File: rtl/txerr_pkg.sv
package txerr_pkg;
  localparam int NFLAG   = 6;
  localparam int F_BUS   = 0;
  localparam int F_FIFO  = 1;
  localparam int F_SYS   = 2;
  localparam int F_RETRY = 3;
  localparam int F_TABT  = 4;
  localparam int F_IABT  = 5;

  // A retry is excessive once the count seen before it already reached a nonzero limit.
  function automatic logic retry_over(input int unsigned seen, input int unsigned limit);
    return (limit != 0) && (seen >= limit);
  endfunction

  function automatic logic any_enabled(input logic [NFLAG-1:0] flags,
                                       input logic [NFLAG-1:0] ens);
    return |(flags & ens);
  endfunction
endpackage

// File: rtl/txerr_flag_bank.sv
module txerr_flag_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= set_i[i] | (q & ~clr_i[i]);
    end
    assign flag_o[i] = q;

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> flag_o[i]);
  end
endmodule

// File: rtl/txerr_retry_cnt.sv
module txerr_retry_cnt #(
  parameter int LIM_W = 8,
  parameter int CNT_W = LIM_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             txn_start_i,
  input  logic             retry_i,
  input  logic             flush_i,
  input  logic [LIM_W-1:0] lim_i,
  output logic             over_o
);
  import txerr_pkg::*;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] base_w;

  assign base_w = txn_start_i ? '0 : cnt_q;
  assign over_o = retry_i && retry_over(32'(base_w), 32'(lim_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             cnt_q <= '0;
    else if (flush_i)                       cnt_q <= '0;
    else if (retry_i && base_w != CNT_MAX)  cnt_q <= base_w + 1'b1;
    else                                    cnt_q <= base_w;
  end

  p_cnt_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_start_i && !flush_i) |=> (cnt_q <= 1));
endmodule

// File: rtl/tx_err_status.sv
module tx_err_status #(
  parameter int DATA_W = 16,
  parameter int LIM_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rsvd_rd_i,
  input  logic              fifo_err_i,
  input  logic              bad_state_i,
  input  logic              retry_i,
  input  logic              txn_start_i,
  input  logic              tgt_abort_i,
  input  logic              init_abort_i,
  input  logic              ctl_reset_i,
  input  logic              reg_wr_i,
  input  logic              reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  import txerr_pkg::*;
  localparam int LIM_LSB = DATA_W - LIM_W;
  localparam int GAP_W   = LIM_LSB - NFLAG;
  localparam int HI_W    = DATA_W - NFLAG;

  logic [NFLAG-1:0] flag_q, set_w, clr_w;
  logic [NFLAG-1:0] en_q;
  logic [LIM_W-1:0] lim_q;
  logic             sys_lock_q;
  logic             retry_over_w;
  logic             irq_q;
  logic             wr_stat_w, wr_ctl_w;

  assign wr_stat_w = reg_wr_i && !reg_addr_i;
  assign wr_ctl_w  = reg_wr_i &&  reg_addr_i;

  always_comb begin
    set_w          = '0;
    set_w[F_BUS]   = rsvd_rd_i;
    set_w[F_FIFO]  = fifo_err_i;
    set_w[F_SYS]   = bad_state_i;
    set_w[F_RETRY] = retry_over_w;
    set_w[F_TABT]  = tgt_abort_i;
    set_w[F_IABT]  = init_abort_i;
    clr_w          = wr_stat_w ? reg_wdata_i[NFLAG-1:0] : '0;
    clr_w[F_SYS]   = clr_w[F_SYS] & ~sys_lock_q;
  end

  txerr_flag_bank #(.N(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(set_w), .clr_i(clr_w), .flag_o(flag_q)
  );

  txerr_retry_cnt #(.LIM_W(LIM_W)) u_retry (
    .clk(clk), .rst_n(rst_n), .txn_start_i(txn_start_i), .retry_i(retry_i),
    .flush_i(ctl_reset_i), .lim_i(lim_q), .over_o(retry_over_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= '0;
      lim_q      <= '0;
      sys_lock_q <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      if (wr_ctl_w) begin
        en_q  <= reg_wdata_i[NFLAG-1:0];
        lim_q <= reg_wdata_i[DATA_W-1:LIM_LSB];
      end
      if (bad_state_i)      sys_lock_q <= 1'b1;
      else if (ctl_reset_i) sys_lock_q <= 1'b0;
      irq_q <= any_enabled(flag_q, en_q);
    end
  end

  assign irq_o       = irq_q;
  assign reg_rdata_o = reg_addr_i ? {lim_q, {GAP_W{1'b0}}, en_q}
                                  : {{HI_W{1'b0}}, flag_q};

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata_i[LIM_LSB-1:NFLAG];

  p_bus_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_rd_i |=> flag_q[F_BUS]);
  p_fifo_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_err_i |=> flag_q[F_FIFO]);
  p_sys_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sys_lock_q |-> flag_q[F_SYS]);
  p_retry_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    retry_over_w |=> flag_q[F_RETRY]);
  p_unlimited_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_q == '0 && !flag_q[F_RETRY]) |=> !flag_q[F_RETRY]);
  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |=> !irq_o);
endmodule

// File: tb/sim_tx_err_status.sv
module sim_tx_err_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rsvd_rd_i = 0, fifo_err_i = 0, bad_state_i = 0, retry_i = 0, txn_start_i = 0;
  logic tgt_abort_i = 0, init_abort_i = 0, ctl_reset_i = 0;
  logic reg_wr_i = 0, reg_addr_i = 0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic irq_o;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tx_err_status u0 (.*);

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1; tick(); reg_wr_i = 0;
  endtask

  task automatic rd(input logic a, output logic [15:0] d);
    reg_addr_i = a; #1; d = reg_rdata_o;
  endtask

  task automatic chk_stat(input string req, input logic [15:0] exp);
    logic [15:0] d;
    rd(0, d); chk(req, d, exp);
  endtask

  task automatic retries(input int n);
    for (int i = 0; i < n; i++) begin retry_i = 1; tick(); retry_i = 0; end
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk_stat("R1 status", 16'h0);
    rd(1, d); chk("R1 control", d, 16'h0);
    chk("R1 irq", irq_o, 0);
  endtask

  task automatic t_bus();
    rsvd_rd_i = 1; tick(); rsvd_rd_i = 0;
    chk_stat("R2 set without enable", 16'h0001);
    tick(); tick();
    chk("R2 no irq when disabled", irq_o, 0);
    wr(1, 16'h0001);
    chk("R10 irq latency", irq_o, 0);
    tick();
    chk("R2 irq when enabled", irq_o, 1);
    wr(0, 16'h0000);
    chk_stat("R9 write zero keeps", 16'h0001);
    wr(0, 16'h0001);
    chk_stat("R9 w1c clears", 16'h0000);
    tick();
    chk("R10 irq falls", irq_o, 0);
    wr(1, 16'h0000);
  endtask

  task automatic t_fifo();
    fifo_err_i = 1; tick();
    chk_stat("R3 set", 16'h0002);
    wr(0, 16'h0002);
    chk_stat("R3 clear ignored while high", 16'h0002);
    fifo_err_i = 0; tick();
    wr(0, 16'h0002);
    chk_stat("R3 clear after drop", 16'h0000);
  endtask

  task automatic t_sys();
    bad_state_i = 1; tick(); bad_state_i = 0;
    chk_stat("R4 set", 16'h0004);
    wr(0, 16'h0004);
    chk_stat("R4 locked before ctl reset", 16'h0004);
    ctl_reset_i = 1; tick(); ctl_reset_i = 0;
    chk_stat("R4 still set after ctl reset", 16'h0004);
    wr(0, 16'h0004);
    chk_stat("R4 cleared after ctl reset", 16'h0000);
  endtask

  task automatic t_retry();
    wr(1, 16'h0300);
    txn_start_i = 1; tick(); txn_start_i = 0;
    retries(3);
    chk_stat("R5 at limit no flag", 16'h0000);
    retries(1);
    chk_stat("R5 over limit sets", 16'h0008);
    wr(0, 16'h0008);
    for (int t = 0; t < 3; t++) begin
      txn_start_i = 1; tick(); txn_start_i = 0;
      retries(2);
    end
    chk_stat("R6 no accumulation", 16'h0000);
    wr(1, 16'h0000);
    txn_start_i = 1; tick(); txn_start_i = 0;
    retries(300);
    chk_stat("R7 unlimited", 16'h0000);
  endtask

  task automatic t_abort();
    tgt_abort_i = 1; tick(); tgt_abort_i = 0;
    chk_stat("R8 target abort", 16'h0010);
    init_abort_i = 1; tick(); init_abort_i = 0;
    chk_stat("R8 initiator abort", 16'h0030);
    tgt_abort_i = 1; wr(0, 16'h0010); tgt_abort_i = 0;
    chk_stat("R9 set wins", 16'h0030);
    wr(0, 16'h0030);
    chk_stat("R9 both cleared", 16'h0000);
  endtask

  task automatic t_irq();
    wr(1, 16'h0020);
    tgt_abort_i = 1; tick(); tgt_abort_i = 0;
    tick();
    chk("R10 other enable no irq", irq_o, 0);
    init_abort_i = 1; tick(); init_abort_i = 0;
    tick();
    chk("R10 bit5 enable irq", irq_o, 1);
    wr(1, 16'h0000);
    tick();
    chk("R10 disable drops irq", irq_o, 0);
    wr(0, 16'h0030);
  endtask

  task automatic t_rsvd();
    logic [15:0] d;
    wr(0, 16'hFFC0);
    chk_stat("R11 status reserved", 16'h0000);
    wr(1, 16'hFFFF);
    rd(1, d); chk("R11 control reserved", d, 16'hFF3F);
    wr(1, 16'h0000);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    t_reset();
    t_bus();
    t_fifo();
    t_sys();
    t_retry();
    t_abort();
    t_irq();
    t_rsvd();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog got=running exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule